// File: doc/BRIEF.md
# Fixed-Priority Maskable Interrupt Unit

This block sits between five interrupt request lines and a small CPU core. It presents one request line toward the core. When the core acknowledges, it returns the source that won and a fixed vector for that source. The order among the lines is wired in hardware and cannot be changed by software.

The highest line is non-maskable. Three vectored lines (C, B, A, from highest to lowest) each carry an individual mask bit. Below them is a general request line. Every line except the non-maskable one is also gated by a global enable flag. The core drives enable, disable and set-mask commands. A read-back bus shows the masks, the enable flag and the pending vectored requests.

Nesting works as follows. Inside a handler, software rewrites the mask bits and then sets the enable flag again. Any higher line that is still unmasked can then break in.

Top module: `irq_prio_unit`

## Requirements
- R1: The grant order is fixed: non-maskable first, then vectored C, then B, then A, then the general line. An acknowledge always takes the highest eligible line.
- R2: A registered non-maskable request drives `irq_out` no matter what the enable flag and the mask bits hold.
- R3: A non-maskable request registers only after a rising edge on `nmi_req` that is still high at the following clock edge. A one-cycle pulse is dropped. The pending state clears when that request is accepted.
- R4: While the enable flag is 0, the vectored lines and the general line cannot drive `irq_out`. `cmd_en` sets the flag and `cmd_dis` clears it.
- R5: Accepting any request clears the enable flag. The flag rises again only through `cmd_en`.
- R6: `cmd_setmask` writes `setmask_data[2:0]` into the masks of A, B and C (bit 0, 1 and 2; a 1 masks the line) only when `setmask_data[3]` is 1. When that bit is 0, the masks keep their value.
- R7: Line C is edge-triggered. A rising edge sets a pending flag that stays set until C is accepted or `cmd_setmask` arrives with `setmask_data[4]` = 1. Lines A and B are level-sensitive.
- R8: `rd_status` holds the masks in bits 2:0, the enable flag in bit 3, and the pending A, B and C requests in bits 4, 5 and 6.
- R9: The cycle after an accepting clock edge, `ack_vld` is 1 for one cycle. `ack_src` then holds the source (0 none, 1 general, 2 A, 3 B, 4 C, 5 non-maskable) and `vec_out` holds 0x24 for non-maskable, 0x3C for C, 0x34 for B, 0x2C for A, or 0x00 for general.
- R10: After a handler masks its own line and sets the enable flag again, a higher unmasked line that rises still drives `irq_out` and wins the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request |
| vec_c_req | input | 1 | Vectored line C, edge-triggered |
| vec_b_req | input | 1 | Vectored line B, level |
| vec_a_req | input | 1 | Vectored line A, level |
| gen_req | input | 1 | General request, level |
| cmd_en | input | 1 | Set global enable |
| cmd_dis | input | 1 | Clear global enable |
| cmd_setmask | input | 1 | Apply setmask_data |
| setmask_data | input | 5 | Masks [2:0], update enable [3], clear C pending [4] |
| ack_in | input | 1 | Core acknowledge |
| irq_out | output | 1 | Request toward the core |
| rd_status | output | 7 | Mask, enable and pending read-back |
| ack_vld | output | 1 | Acknowledge result valid |
| ack_src | output | 3 | Accepted source code |
| vec_out | output | 8 | Vector of accepted source |

## Verification
`irq_out` and the pending bits of A and B follow the inputs without delay. The bench therefore samples them one time unit after it drives a stimulus. Line C, the enable flag and the masks change at the next clock edge. The non-maskable line needs two edges before it shows. The acknowledge result appears in the cycle after the accepting edge. Each task drives its inputs just after a rising edge and then waits the exact number of edges listed for that result before it compares. A dropped non-maskable pulse and a masked line are checked at `irq_out` and `rd_status`.

// File: rtl/irq_prio_pkg.sv
// Package: shared source codes and vector constants for the interrupt unit.
// Assumes: source codes fit in 3 bits; vectors are 8 bits wide.
package irq_prio_pkg;

    localparam int NUM_SRC = 5;   // grant vector width, index 4 = highest
    localparam int VEC_W   = 8;
    localparam int MSK_W   = 3;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_GEN  = 3'd1,
        SRC_A    = 3'd2,
        SRC_B    = 3'd3,
        SRC_C    = 3'd4,
        SRC_NMI  = 3'd5
    } src_t;

    localparam logic [VEC_W-1:0] VEC_NMI = 8'h24;
    localparam logic [VEC_W-1:0] VEC_C   = 8'h3C;
    localparam logic [VEC_W-1:0] VEC_B   = 8'h34;
    localparam logic [VEC_W-1:0] VEC_A   = 8'h2C;
    localparam logic [VEC_W-1:0] VEC_GEN = 8'h00;

endpackage

// File: rtl/irq_nmi_detect.sv
// Module: irq_nmi_detect
// Registers a non-maskable request after a rising edge that is still high
// one clock later; the pending state clears on accept.
// Assumes: the input is synchronous to clk.
module irq_nmi_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic accept_nmi,
    output logic nmi_pend
);
    logic prev_q;
    logic arm_q;

    // Track the previous level and arm on a fresh rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            prev_q <= nmi_in;
            arm_q  <= nmi_in & ~prev_q;
        end
    end

    // Latch the request once the armed edge is confirmed by a sustained high level.
    always_ff @(posedge clk) begin
        if (!rst_n)                 nmi_pend <= 1'b0;
        else if (arm_q && nmi_in)   nmi_pend <= 1'b1;
        else if (accept_nmi)        nmi_pend <= 1'b0;
    end

    AST_NMI_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pend) |-> $past(arm_q)); // R3
    AST_NMI_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_nmi && !(arm_q && nmi_in)) |=> !nmi_pend); // R3
endmodule

// File: rtl/irq_ctrl_regs.sv
// Module: irq_ctrl_regs
// Holds the global enable flag, the three individual masks and the
// pending flag of the edge-triggered line C.
// Assumes: commands are single-cycle strobes; accept outranks enable.
module irq_ctrl_regs
    import irq_prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_en,
    input  logic             cmd_dis,
    input  logic             cmd_setmask,
    input  logic [4:0]       setmask_data,
    input  logic             accept,
    input  logic             accept_c,
    input  logic             c_in,
    output logic             ie,
    output logic [MSK_W-1:0] mask,
    output logic             c_pend
);
    localparam int UPD_BIT = MSK_W;      // update-enable bit position
    localparam int CLR_BIT = MSK_W + 1;  // clear-C-pending bit position

    logic c_prev;

    // Global enable: cleared by accept or disable, set only by enable.
    always_ff @(posedge clk) begin
        if (!rst_n)        ie <= 1'b0;
        else if (accept)   ie <= 1'b0;
        else if (cmd_dis)  ie <= 1'b0;
        else if (cmd_en)   ie <= 1'b1;
    end

    // Individual masks: written only when the update-enable bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (cmd_setmask && setmask_data[UPD_BIT])
            mask <= setmask_data[MSK_W-1:0];
    end

    // Line C edge memory.
    always_ff @(posedge clk) begin
        if (!rst_n) c_prev <= 1'b0;
        else        c_prev <= c_in;
    end

    // Line C pending: a new edge wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            c_pend <= 1'b0;
        else if (c_in && !c_prev)
            c_pend <= 1'b1;
        else if (accept_c || (cmd_setmask && setmask_data[CLR_BIT]))
            c_pend <= 1'b0;
    end

    AST_IE_CLEARED_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ie); // R5
    AST_IE_RISES_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ie) |-> $past(cmd_en)); // R5
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_setmask && setmask_data[UPD_BIT]) |=> $stable(mask)); // R6
    AST_C_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (c_in && !c_prev) |=> c_pend); // R7
endmodule

// File: rtl/irq_prio_enc.sv
// Module: irq_prio_enc
// Fixed priority picker: the highest index among eligible requests wins.
// Assumes: index N-1 is the highest-priority line.
module irq_prio_enc #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N-1:0] above;   // above[i]: some line higher than i is requesting

    assign above[N-1] = 1'b0;

    genvar gi;
    generate
        for (gi = N - 2; gi >= 0; gi--) begin : g_chain
            assign above[gi] = above[gi+1] | req[gi+1];
        end
        for (gi = 0; gi < N; gi++) begin : g_grant
            assign grant[gi] = req[gi] & ~above[gi];
        end
    endgenerate

    // Summary of any eligible request.
    always_comb any = |req;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R1
    AST_GRANT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        req[N-1] |-> grant[N-1]); // R1
    AST_GRANT_WHEN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> $countones(grant) == 1); // R1
endmodule

// File: rtl/irq_ack_out.sv
// Module: irq_ack_out
// Registers the accepted source and its fixed vector for one cycle.
// Assumes: grant is one-hot or zero, index order from irq_prio_pkg.
module irq_ack_out
    import irq_prio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [NUM_SRC-1:0] grant,
    output logic               ack_vld,
    output logic [2:0]         ack_src,
    output logic [VEC_W-1:0]   vec_out
);
    src_t             src_d;
    logic [VEC_W-1:0] vec_d;

    // Translate the one-hot grant into a source code and vector.
    always_comb begin
        src_d = SRC_NONE;
        vec_d = '0;
        unique case (1'b1)
            grant[4]: begin src_d = SRC_NMI; vec_d = VEC_NMI; end
            grant[3]: begin src_d = SRC_C;   vec_d = VEC_C;   end
            grant[2]: begin src_d = SRC_B;   vec_d = VEC_B;   end
            grant[1]: begin src_d = SRC_A;   vec_d = VEC_A;   end
            grant[0]: begin src_d = SRC_GEN; vec_d = VEC_GEN; end
            default:  begin src_d = SRC_NONE; vec_d = '0;     end
        endcase
    end

    // Capture the result on an accepting edge; hold it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_vld <= 1'b0;
            ack_src <= SRC_NONE;
            vec_out <= '0;
        end else if (accept) begin
            ack_vld <= 1'b1;
            ack_src <= src_d;
            vec_out <= vec_d;
        end else begin
            ack_vld <= 1'b0;
            ack_src <= SRC_NONE;
            vec_out <= '0;
        end
    end

    AST_VEC_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && ack_src == SRC_NMI) |-> vec_out == VEC_NMI); // R9
    AST_VEC_C: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && ack_src == SRC_C) |-> vec_out == VEC_C); // R9
    AST_ACK_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> ack_src != SRC_NONE); // R9
endmodule

// File: rtl/irq_prio_unit.sv
// Module: irq_prio_unit (top)
// Five-line fixed-priority interrupt unit: non-maskable, three vectored
// lines with masks, one general line; one request and vector toward a core.
// Assumes: all inputs are synchronous; ack_in is only meaningful with irq_out.
module irq_prio_unit
    import irq_prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_req,
    input  logic             vec_c_req,
    input  logic             vec_b_req,
    input  logic             vec_a_req,
    input  logic             gen_req,
    input  logic             cmd_en,
    input  logic             cmd_dis,
    input  logic             cmd_setmask,
    input  logic [4:0]       setmask_data,
    input  logic             ack_in,
    output logic             irq_out,
    output logic [6:0]       rd_status,
    output logic             ack_vld,
    output logic [2:0]       ack_src,
    output logic [VEC_W-1:0] vec_out
);
    logic               nmi_pend;
    logic               ie;
    logic [MSK_W-1:0]   mask;
    logic               c_pend;
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] grant;
    logic               any_req;
    logic               accept;

    // Eligible requests in priority order, index 4 highest.
    always_comb begin
        elig[4] = nmi_pend;
        elig[3] = c_pend    & ~mask[2] & ie;
        elig[2] = vec_b_req & ~mask[1] & ie;
        elig[1] = vec_a_req & ~mask[0] & ie;
        elig[0] = gen_req   & ie;
    end

    // Request toward the core, acceptance strobe and read-back bus.
    always_comb begin
        irq_out   = any_req;
        accept    = ack_in & any_req;
        rd_status = {c_pend, vec_b_req, vec_a_req, ie, mask};
    end

    irq_nmi_detect u_nmi (
        .clk        (clk),
        .rst_n      (rst_n),
        .nmi_in     (nmi_req),
        .accept_nmi (accept & grant[4]),
        .nmi_pend   (nmi_pend)
    );

    irq_ctrl_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_en       (cmd_en),
        .cmd_dis      (cmd_dis),
        .cmd_setmask  (cmd_setmask),
        .setmask_data (setmask_data),
        .accept       (accept),
        .accept_c     (accept & grant[3]),
        .c_in         (vec_c_req),
        .ie           (ie),
        .mask         (mask),
        .c_pend       (c_pend)
    );

    irq_prio_enc #(.N(NUM_SRC)) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (elig),
        .grant (grant),
        .any   (any_req)
    );

    irq_ack_out u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .grant   (grant),
        .ack_vld (ack_vld),
        .ack_src (ack_src),
        .vec_out (vec_out)
    );

    AST_NMI_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend |-> irq_out); // R2
    AST_GATED_BY_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie && !nmi_pend) |-> !irq_out); // R4
    AST_MASKED_A_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[0] && !gen_req && !vec_b_req && !c_pend && !nmi_pend) |-> !irq_out); // R6
endmodule

// File: tb/test_irq_prio_unit.sv
module test_irq_prio_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_req = 0, vec_c_req = 0, vec_b_req = 0, vec_a_req = 0, gen_req = 0;
    logic       cmd_en = 0, cmd_dis = 0, cmd_setmask = 0, ack_in = 0;
    logic [4:0] setmask_data = '0;
    logic       irq_out, ack_vld;
    logic [6:0] rd_status;
    logic [2:0] ack_src;
    logic [7:0] vec_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    irq_prio_unit i_irq_prio_unit (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .vec_c_req(vec_c_req),
        .vec_b_req(vec_b_req), .vec_a_req(vec_a_req), .gen_req(gen_req),
        .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_setmask(cmd_setmask),
        .setmask_data(setmask_data), .ack_in(ack_in), .irq_out(irq_out),
        .rd_status(rd_status), .ack_vld(ack_vld), .ack_src(ack_src), .vec_out(vec_out)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic enable();
        cmd_en = 1; tick(); cmd_en = 0;
    endtask

    task automatic setmask(logic [4:0] d);
        setmask_data = d; cmd_setmask = 1; tick(); cmd_setmask = 0; setmask_data = '0;
    endtask

    // Acknowledge, then check the result in the following cycle.
    task automatic ack_expect(string req, int src, int vec);
        ack_in = 1; tick(); ack_in = 0;
        check({req, " ack_vld"}, ack_vld, 1);
        check({req, " ack_src"}, ack_src, src);
        check({req, " vec_out"}, vec_out, vec);
    endtask

    task automatic t_reset();
        check("R8 reset status", rd_status, 0);
        check("R4 reset irq", irq_out, 0);
        check("R9 reset ack_vld", ack_vld, 0);
    endtask

    task automatic t_enable_gate();
        gen_req = 1; vec_b_req = 1; #1;
        check("R4 blocked while disabled", irq_out, 0);
        check("R8 level pending B", rd_status[5], 1);
        enable();
        check("R4 enable flag set", rd_status[3], 1);
        check("R4 request after enable", irq_out, 1);
        ack_expect("R1 B over general", 3, 8'h34);
        check("R5 enable cleared on accept", rd_status[3], 0);
        check("R5 irq quiet after accept", irq_out, 0);
        enable(); cmd_dis = 1; tick(); cmd_dis = 0;
        check("R4 disable clears flag", irq_out, 0);
        gen_req = 0; vec_b_req = 0;
    endtask

    task automatic t_priority();
        gen_req = 1; vec_a_req = 1; vec_b_req = 1;
        enable();
        ack_expect("R1 B first", 3, 8'h34);
        vec_b_req = 0; enable();
        ack_expect("R9 A vector", 2, 8'h2C);
        vec_a_req = 0; enable();
        ack_expect("R9 general vector", 1, 8'h00);
        gen_req = 0; tick();
        check("R9 ack_vld single cycle", ack_vld, 0);
    endtask

    task automatic t_mask();
        setmask(5'b01011);
        check("R6 masks written", rd_status[2:0], 3'b011);
        vec_a_req = 1; enable();
        check("R6 masked A blocked", irq_out, 0);
        setmask(5'b00101);
        check("R6 no update without enable bit", rd_status[2:0], 3'b011);
        setmask(5'b01000);
        check("R6 unmask A", irq_out, 1);
        ack_expect("R6 A after unmask", 2, 8'h2C);
        vec_a_req = 0;
    endtask

    task automatic t_edge_c();
        vec_c_req = 1; tick(); vec_c_req = 0;
        check("R7 C edge latched", rd_status[6], 1);
        tick();
        check("R7 C held after line drops", rd_status[6], 1);
        setmask(5'b11000);
        check("R7 setmask clears C", rd_status[6], 0);
        vec_c_req = 1; tick(); vec_c_req = 0;
        vec_b_req = 1; enable();
        ack_expect("R1 C over B", 4, 8'h3C);
        check("R7 C cleared by accept", rd_status[6], 0);
        vec_b_req = 0;
    endtask

    task automatic t_nmi();
        setmask(5'b01111);
        nmi_req = 1; tick(); nmi_req = 0; tick(); tick();
        check("R3 one-cycle pulse dropped", irq_out, 0);
        nmi_req = 1; tick(); tick();
        check("R2 NMI passes disable and masks", irq_out, 1);
        tick();
        check("R3 no retrigger on held level", irq_out, 1);
        ack_expect("R9 NMI vector", 5, 8'h24);
        check("R3 NMI cleared by accept", irq_out, 0);
        tick();
        check("R3 held level does not re-register", irq_out, 0);
        nmi_req = 0; setmask(5'b01000);
    endtask

    task automatic t_preempt();
        vec_a_req = 1; enable();
        ack_expect("R10 handler entry A", 2, 8'h2C);
        setmask(5'b01001); enable();
        check("R10 own line masked", irq_out, 0);
        vec_c_req = 1; tick();
        check("R10 higher line preempts", irq_out, 1);
        ack_expect("R10 C wins", 4, 8'h3C);
        vec_c_req = 0; vec_a_req = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1; tick();
        t_reset();
        t_enable_gate();
        t_priority();
        t_mask();
        t_edge_c();
        t_nmi();
        t_preempt();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule